// File: doc/BRIEF.md
# Memory-Destination ALU Sequencer

This block runs the bus cycles of 8-bit ALU instructions whose result lands in a direct-page byte instead of a register. Once a supported opcode is accepted, it walks a fixed cycle pattern. It fetches operand bytes from the program stream and reads the source and the destination from the direct page. In the final cycle it either writes the result back to the destination byte or leaves the bus idle.

Three addressing forms are handled. The first is indirect through X as destination with indirect through Y as source. The second is direct-page to direct-page. The third is an immediate byte into a direct-page byte. Six operations are supported: OR, AND, EOR, compare, add-with-carry and subtract-with-carry. Compare updates flags and never writes memory. Its final cycle is idle, so every opcode of a form takes the same number of cycles. The surrounding core fetches the opcode, owns the program counter and the direct-page base, and merges the flag outputs into its status word using the mask output.

Each bus cycle completes in the cycle it is requested. Read data is sampled at the rising edge that ends the cycle.

Top module: `mm_alu_seq`

## Requirements
- R1: An opcode is accepted only while `busy_o` is low and `op_valid_i` is high. The accepted set is alu code {0x0,0x2,0x4,0x6,0x8,0xA} in the high nibble ORed with low byte 0x19 (X/Y form), 0x09 (page-to-page form) or 0x18 (immediate form). Any other opcode leaves `busy_o` low and the bus idle.
- R2: X/Y form, one cycle per step after accept: idle; page read at Y (source); page read at X (destination); final cycle.
- R3: Page-to-page form: program read (source offset); page read at that offset; program read (destination offset); page read at that offset; final cycle.
- R4: Immediate form: program read (immediate, used as source); program read (destination offset); page read at that offset; final cycle.
- R5: The destination byte is the left operand and the source byte the right operand. For non-compare operations the final cycle writes the result to the destination address.
- R6: Add (high nibble 0x8/0x9) gives dst+src+`carry_i`. It updates all five flags: N = result bit 7, V = signed overflow, H = carry out of bit 3, Z = result zero, C = carry out of bit 7.
- R7: Subtract (high nibble 0xA/0xB) gives dst-src-(1-`carry_i`). It updates all five flags, with C = no borrow and H = no borrow out of the low nibble.
- R8: OR, AND and EOR (high nibbles 0x0/0x1, 0x2/0x3, 0x4/0x5) update only N and Z.
- R9: Compare (high nibble 0x6/0x7) sets N, Z and C from dst-src, ignoring `carry_i`, with C = dst >= src. Its final cycle is idle and memory is left unchanged.
- R10: The write in the final cycle uses the same page address as the destination read.
- R11: `busy_o` is high from the cycle after accept through the final cycle. `done_o` pulses in the final cycle only.
- R12: Flags are presented as {N,V,H,Z,C} on bits 4..0 of `flags_o`, and `flag_mask_o` marks the flags the last instruction wrote. Both update in the final cycle and hold until the next instruction. Flags outside the mask read zero. After reset both are zero, `busy_o` is low and the bus is idle.
- R13: Bus cycle codes on `bus_kind_o`: 0 idle, 1 program read, 2 page read, 3 page write. `bus_addr_o` carries the page offset on codes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Opcode offered |
| op_i | input | 8 | Opcode |
| x_i | input | DATA_W | X index, sampled at accept |
| y_i | input | DATA_W | Y index, sampled at accept |
| carry_i | input | 1 | Carry flag in, used by add and subtract |
| bus_kind_o | output | 2 | Bus cycle code (R13) |
| bus_addr_o | output | DATA_W | Page offset of a page read or write |
| bus_wdata_o | output | DATA_W | Write data |
| bus_rdata_i | input | DATA_W | Read data for the current cycle |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Final cycle of an instruction |
| flags_o | output | 5 | {N,V,H,Z,C} |
| flag_mask_o | output | 5 | Flags written by the last instruction |

## Verification
Several properties are checked on every cycle. The bus is quiet while not busy. A write never occurs for a compare opcode and always targets the last page address read. A write happens only in the final cycle. Busy drops right after done, and the flags never show bits outside their mask. The per-form cycle order, the operand order and the arithmetic of every operation and carry-in can only be shown by the bench. It sweeps all eighteen opcodes over edge-value operand pairs against an arithmetic model and walks all other opcode values to confirm they are refused.

// File: rtl/mm_alu_pkg.sv
package mm_alu_pkg;
  localparam int FLAG_W = 5;
  localparam int OP_W   = 8;

  typedef enum logic [2:0] {
    ALU_OR  = 3'd0,
    ALU_AND = 3'd1,
    ALU_EOR = 3'd2,
    ALU_CMP = 3'd3,
    ALU_ADC = 3'd4,
    ALU_SBC = 3'd5
  } alu_op_e;

  typedef enum logic [1:0] {
    FORM_XY  = 2'd0,
    FORM_DD  = 2'd1,
    FORM_IMM = 2'd2
  } form_e;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_PC_RD = 2'd1,
    BUS_DP_RD = 2'd2,
    BUS_DP_WR = 2'd3
  } bus_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IO,
    ST_PC_SRC,
    ST_RD_SRC,
    ST_PC_IMM,
    ST_PC_DST,
    ST_RD_DST,
    ST_FINAL
  } seq_st_e;

  typedef struct packed {
    logic n;
    logic v;
    logic h;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/mm_decode.sv
module mm_decode
  import mm_alu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output logic            valid_o,
  output form_e           form_o,
  output alu_op_e         alu_o
);
  logic [2:0] alu_code;
  logic [3:0] lo_nib;

  assign alu_code = op_i[7:5];
  assign lo_nib   = op_i[3:0];
  assign alu_o    = alu_op_e'(alu_code);

  always_comb begin
    valid_o = 1'b0;
    form_o  = FORM_XY;
    if (alu_code <= 3'd5) begin
      if (lo_nib == 4'h9) begin
        valid_o = 1'b1;
        form_o  = op_i[4] ? FORM_XY : FORM_DD;
      end else if (lo_nib == 4'h8 && op_i[4]) begin
        valid_o = 1'b1;
        form_o  = FORM_IMM;
      end
    end
  end
endmodule

// File: rtl/mm_alu.sv
module mm_alu
  import mm_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flags_o,
  output flags_t            mask_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] rhs;
  logic              cin;
  logic [DATA_W:0]   sum;
  logic [HALF_W:0]   hsum;

  always_comb begin
    rhs  = (op_i == ALU_ADC) ? src_i : ~src_i;
    cin  = (op_i == ALU_CMP) ? 1'b1 : carry_i;
    sum  = {1'b0, dst_i} + {1'b0, rhs} + {{DATA_W{1'b0}}, cin};
    hsum = {1'b0, dst_i[HALF_W-1:0]} + {1'b0, rhs[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
  end

  always_comb begin
    res_o  = dst_i;
    mask_o = '0;
    unique case (op_i)
      ALU_OR:  begin res_o = dst_i | src_i; mask_o = 5'b10010; end
      ALU_AND: begin res_o = dst_i & src_i; mask_o = 5'b10010; end
      ALU_EOR: begin res_o = dst_i ^ src_i; mask_o = 5'b10010; end
      ALU_CMP: begin res_o = sum[DATA_W-1:0]; mask_o = 5'b10011; end
      ALU_ADC, ALU_SBC: begin res_o = sum[DATA_W-1:0]; mask_o = 5'b11111; end
      default: begin res_o = dst_i; mask_o = '0; end
    endcase
  end

  always_comb begin
    flags_o.n = res_o[DATA_W-1] & mask_o.n;
    flags_o.v = (~(dst_i[DATA_W-1] ^ rhs[DATA_W-1]) & (dst_i[DATA_W-1] ^ sum[DATA_W-1])) & mask_o.v;
    flags_o.h = hsum[HALF_W] & mask_o.h;
    flags_o.z = (res_o == '0) & mask_o.z;
    flags_o.c = sum[DATA_W] & mask_o.c;
  end
endmodule

// File: rtl/mm_seq.sv
module mm_seq
  import mm_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  form_e             form_i,
  input  alu_op_e           alu_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] res_i,
  input  flags_t            flags_i,
  input  flags_t            mask_i,
  output alu_op_e           alu_o,
  output logic [DATA_W-1:0] src_o,
  output bus_kind_e         kind_o,
  output logic [DATA_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output flags_t            flags_o,
  output flags_t            mask_o
);
  seq_st_e           st_q;
  form_e             form_q;
  alu_op_e           alu_q;
  logic [DATA_W-1:0] src_addr_q;
  logic [DATA_W-1:0] dst_addr_q;
  logic [DATA_W-1:0] src_q;
  logic [DATA_W-1:0] res_q;
  flags_t            flags_q;
  flags_t            mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      form_q     <= FORM_XY;
      alu_q      <= ALU_OR;
      src_addr_q <= '0;
      dst_addr_q <= '0;
      src_q      <= '0;
      res_q      <= '0;
      flags_q    <= '0;
      mask_q     <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          form_q     <= form_i;
          alu_q      <= alu_i;
          src_addr_q <= y_i;
          dst_addr_q <= x_i;
          unique case (form_i)
            FORM_XY:  st_q <= ST_IO;
            FORM_DD:  st_q <= ST_PC_SRC;
            default:  st_q <= ST_PC_IMM;
          endcase
        end
        ST_IO: st_q <= ST_RD_SRC;
        ST_PC_SRC: begin
          src_addr_q <= rdata_i;
          st_q       <= ST_RD_SRC;
        end
        ST_RD_SRC: begin
          src_q <= rdata_i;
          st_q  <= (form_q == FORM_XY) ? ST_RD_DST : ST_PC_DST;
        end
        ST_PC_IMM: begin
          src_q <= rdata_i;
          st_q  <= ST_PC_DST;
        end
        ST_PC_DST: begin
          dst_addr_q <= rdata_i;
          st_q       <= ST_RD_DST;
        end
        ST_RD_DST: begin
          res_q   <= res_i;
          flags_q <= flags_i;
          mask_q  <= mask_i;
          st_q    <= ST_FINAL;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    kind_o = BUS_IDLE;
    addr_o = '0;
    unique case (st_q)
      ST_PC_SRC, ST_PC_IMM, ST_PC_DST: kind_o = BUS_PC_RD;
      ST_RD_SRC: begin kind_o = BUS_DP_RD; addr_o = src_addr_q; end
      ST_RD_DST: begin kind_o = BUS_DP_RD; addr_o = dst_addr_q; end
      ST_FINAL: if (alu_q != ALU_CMP) begin
        kind_o = BUS_DP_WR;
        addr_o = dst_addr_q;
      end
      default: ;
    endcase
  end

  assign wdata_o = (kind_o == BUS_DP_WR) ? res_q : '0;
  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = (st_q == ST_FINAL);
  assign alu_o   = alu_q;
  assign src_o   = src_q;
  assign flags_o = flags_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/mm_alu_seq.sv
module mm_alu_seq
  import mm_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [7:0]        op_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              carry_i,
  output logic [1:0]        bus_kind_o,
  output logic [DATA_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [4:0]        flags_o,
  output logic [4:0]        flag_mask_o
);
  logic              dec_valid;
  form_e             dec_form;
  alu_op_e           dec_alu;
  alu_op_e           cur_alu;
  logic [DATA_W-1:0] src_val;
  logic [DATA_W-1:0] alu_res;
  flags_t            alu_flags;
  flags_t            alu_mask;
  flags_t            flags_q;
  flags_t            mask_q;
  bus_kind_e         kind;
  logic              start;

  assign start = op_valid_i & dec_valid & ~busy_o;

  mm_decode u_dec (
    .op_i   (op_i),
    .valid_o(dec_valid),
    .form_o (dec_form),
    .alu_o  (dec_alu)
  );

  mm_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i   (cur_alu),
    .dst_i  (bus_rdata_i),
    .src_i  (src_val),
    .carry_i(carry_i),
    .res_o  (alu_res),
    .flags_o(alu_flags),
    .mask_o (alu_mask)
  );

  mm_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .form_i (dec_form),
    .alu_i  (dec_alu),
    .x_i    (x_i),
    .y_i    (y_i),
    .rdata_i(bus_rdata_i),
    .res_i  (alu_res),
    .flags_i(alu_flags),
    .mask_i (alu_mask),
    .alu_o  (cur_alu),
    .src_o  (src_val),
    .kind_o (kind),
    .addr_o (bus_addr_o),
    .wdata_o(bus_wdata_o),
    .busy_o (busy_o),
    .done_o (done_o),
    .flags_o(flags_q),
    .mask_o (mask_q)
  );

  assign bus_kind_o  = kind;
  assign flags_o     = flags_q;
  assign flag_mask_o = mask_q;
endmodule

// File: rtl/mm_alu_seq_chk.sv
module mm_alu_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [7:0]        op_i,
  input logic [1:0]        bus_kind_o,
  input logic [DATA_W-1:0] bus_addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [4:0]        flags_o,
  input logic [4:0]        flag_mask_o
);
  logic [7:0]        op_q;
  logic [DATA_W-1:0] rd_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= '0;
      rd_addr_q <= '0;
    end else begin
      if (!busy_o) op_q <= op_i;
      if (bus_kind_o == 2'd2) rd_addr_q <= bus_addr_o;
    end
  end

  AST_IDLE_BUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> bus_kind_o == 2'd0); // R1
  AST_CMP_NEVER_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_kind_o == 2'd3 |-> op_q[7:5] != 3'd3); // R9
  AST_WRITE_AT_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_kind_o == 2'd3 |-> bus_addr_o == rd_addr_q); // R10
  AST_WRITE_IN_FINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_kind_o == 2'd3 |-> done_o); // R11
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o); // R11
  AST_DONE_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R11
  AST_FLAGS_IN_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o & ~flag_mask_o) == 5'd0); // R12
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(flags_o)); // R12
endmodule

bind mm_alu_seq mm_alu_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_i       (op_i),
  .bus_kind_o (bus_kind_o),
  .bus_addr_o (bus_addr_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .flags_o    (flags_o),
  .flag_mask_o(flag_mask_o)
);

// File: tb/mm_alu_seq_tb.sv
module mm_alu_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [7:0] op = 8'h00;
  logic [7:0] x_v = 8'h00;
  logic [7:0] y_v = 8'h00;
  logic       cin = 1'b0;
  logic [1:0] kind;
  logic [7:0] addr, wdata, rdata;
  logic       busy, done;
  logic [4:0] flags, fmask;

  logic [7:0] mem [256];
  logic [7:0] prog [4];
  int         pc_idx;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         finished = 0;

  always #5 clk = ~clk;

  mm_alu_seq #(.DATA_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op),
    .x_i(x_v), .y_i(y_v), .carry_i(cin),
    .bus_kind_o(kind), .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_rdata_i(rdata),
    .busy_o(busy), .done_o(done), .flags_o(flags), .flag_mask_o(fmask)
  );

  // bus model, R13 codes
  always_comb begin
    if (kind == 2'd1) rdata = (pc_idx < 4) ? prog[pc_idx] : 8'h00;
    else if (kind == 2'd2) rdata = mem[addr];
    else rdata = 8'h00;
  end

  always @(posedge clk) begin
    if (kind == 2'd1) pc_idx <= pc_idx + 1;
    if (kind == 2'd3) mem[addr] <= wdata;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench arithmetic model: returns {flags, mask, result}
  function automatic logic [17:0] model(input int alu, input int d, input int s, input int c);
    int r; logic nf, vf, hf, zf, cf; logic [4:0] m; logic [7:0] r8;
    nf = 0; vf = 0; hf = 0; zf = 0; cf = 0; r = d;
    case (alu)
      0: begin r = d | s; m = 5'b10010; end
      1: begin r = d & s; m = 5'b10010; end
      2: begin r = d ^ s; m = 5'b10010; end
      3: begin r = d - s; cf = (d >= s); m = 5'b10011; end
      4: begin r = d + s + c; cf = (r > 255); hf = ((d & 15) + (s & 15) + c) > 15; m = 5'b11111; end
      default: begin r = d - s - (1 - c); cf = (r >= 0); hf = ((d & 15) - (s & 15) - (1 - c)) >= 0; m = 5'b11111; end
    endcase
    r8 = r[7:0];
    nf = r8[7];
    zf = (r8 == 8'h00);
    if (alu == 4) vf = (((d ^ r8) & (s ^ r8) & 8'h80) != 0);
    if (alu == 5) vf = (((d ^ s) & (d ^ r8) & 8'h80) != 0);
    return {({nf, vf, hf, zf, cf} & m), m, r8};
  endfunction

  // form: 0 X/Y, 1 page-to-page, 2 immediate
  task automatic run_op(input int form, input int alu, input int sv, input int dv, input int c, input int k);
    int exp_kind [6]; int exp_addr [6]; int n_exp; int got_kind [8]; int got_addr [8]; int n_got;
    int da; int sa; logic [17:0] mr; bit seq_ok; string rq;
    logic [7:0] opc;
    opc = {alu[2:0], 5'b0} | ((form == 0) ? 8'h19 : (form == 1) ? 8'h09 : 8'h18);
    sa = 8'h80 + k; da = 8'h10 + k;
    if (form == 0) begin y_v = sa[7:0]; x_v = da[7:0]; end
    else begin x_v = 8'h33; y_v = 8'h44; end
    if (form == 1) begin prog[0] = sa[7:0]; prog[1] = da[7:0]; end
    if (form == 2) begin prog[0] = sv[7:0]; prog[1] = da[7:0]; end
    mem[sa] = sv[7:0]; mem[da] = dv[7:0];
    cin = c[0];
    pc_idx = 0;
    n_exp = 0;
    if (form == 0) begin
      exp_kind[0] = 0; exp_addr[0] = 0;
      exp_kind[1] = 2; exp_addr[1] = sa;
      exp_kind[2] = 2; exp_addr[2] = da;
      n_exp = 3; rq = "R2";
    end else if (form == 1) begin
      exp_kind[0] = 1; exp_addr[0] = 0;
      exp_kind[1] = 2; exp_addr[1] = sa;
      exp_kind[2] = 1; exp_addr[2] = 0;
      exp_kind[3] = 2; exp_addr[3] = da;
      n_exp = 4; rq = "R3";
    end else begin
      exp_kind[0] = 1; exp_addr[0] = 0;
      exp_kind[1] = 1; exp_addr[1] = 0;
      exp_kind[2] = 2; exp_addr[2] = da;
      n_exp = 3; rq = "R4";
    end
    exp_kind[n_exp] = (alu == 3) ? 0 : 3;
    exp_addr[n_exp] = (alu == 3) ? 0 : da;   // R10 write at destination
    n_exp++;
    op = opc; op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    n_got = 0;
    for (int i = 0; i < 8; i++) begin
      got_kind[i] = kind; got_addr[i] = addr;
      n_got++;
      if (!busy || done) break;
      @(negedge clk);
    end
    seq_ok = (n_got == n_exp);
    for (int i = 0; i < n_exp; i++)
      if (i < n_got && (got_kind[i] != exp_kind[i] || got_addr[i] != exp_addr[i])) seq_ok = 0;
    check(seq_ok && done, rq, {n_got[7:0], got_kind[0][7:0]}, {n_exp[7:0], exp_kind[0][7:0]});
    check(busy && done, "R11", {busy, done}, 2'b11);
    @(negedge clk);
    mr = model(alu, dv, sv, c);
    check(!busy, "R11", busy, 0);
    if (alu == 3) check(mem[da] == dv[7:0], "R9", mem[da], dv);
    else if (alu >= 4) check(mem[da] == mr[7:0], (alu == 4) ? "R6" : "R7", mem[da], mr[7:0]);
    else check(mem[da] == mr[7:0], "R5", mem[da], mr[7:0]);
    check(flags == mr[17:13], (alu == 3) ? "R9" : (alu == 4) ? "R6" : (alu == 5) ? "R7" : "R8", flags, mr[17:13]);
    check(fmask == mr[12:8], "R12", fmask, mr[12:8]);
  endtask

  int sv_l [6] = '{8'h01, 8'h01, 8'h80, 8'h01, 8'h01, 8'hA0};
  int dv_l [6] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h0F, 8'h50};

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    for (int i = 0; i < 4; i++) prog[i] = 8'h00;
    pc_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && kind == 2'd0 && flags == 5'd0 && fmask == 5'd0, "R12",
          {busy, kind, flags, fmask}, 0);

    // R1 refusal sweep over every non-listed opcode
    for (int o = 0; o < 256; o++) begin
      bit listed = 0;
      for (int a = 0; a < 6; a++) begin
        if (o == ((a << 5) | 8'h19) || o == ((a << 5) | 8'h09) || o == ((a << 5) | 8'h18)) listed = 1;
      end
      if (!listed) begin
        op = 8'(o); op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        check(!busy && kind == 2'd0, "R1", {busy, kind}, 0);
      end
    end

    // R2..R10 sweep: every form, op, operand pair and carry in
    for (int f = 0; f < 3; f++)
      for (int a = 0; a < 6; a++)
        for (int p = 0; p < 6; p++)
          for (int c = 0; c < 2; c++) begin
            run_op(f, a, sv_l[p], dv_l[p], c, p * 2 + c);
            run_op(f, a, dv_l[p], sv_l[p], c, p * 2 + c + 16);  // R5 swapped order
          end

    // R12 flags hold while idle
    begin
      logic [4:0] f0;
      f0 = flags;
      op = 8'h00; op_valid = 1'b1;
      repeat (3) @(negedge clk);
      op_valid = 1'b0;
      check(flags == f0 && !busy, "R12", flags, f0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule